// File: doc/BRIEF.md
# Adaptive Checkpoint Period Controller

This controller paces roll-back checkpoints for a pair of lock-stepped processing nodes. Time runs in adjustment periods measured in clock cycles. At the close of each period it takes the number of clean and faulty execution segments seen in that period, from an outside history counter. From these it forms a fresh error-probability estimate in Q0.16. It then asks an outside lookup for the checkpoint count to use in the coming period. The request carries the estimate and the period length. The controller spaces that many checkpoint strobes evenly across the next period.

A mode input picks between two schemes. With `mode_adapt` low, the period length stays at the value loaded at start. With it high, each period is resized by a fixed fraction of itself (alpha = 9830/65536, about 0.15). The period shrinks when the estimate rose and grows otherwise, and it is always held inside a programmable window.

The controller is a four-state machine:
- IDLE waits after reset. IDLE goes to REQ on `start`.
- REQ holds the lookup request. REQ goes to RUN when `rsp_valid` arrives.
- RUN counts out the period and issues strobes. RUN goes to EVAL on the last cycle of the period.
- EVAL lasts one cycle. It updates the estimate and the period, then always goes back to REQ.

Top module: `ckp_adapt_ctrl`

## Requirements
- R1: A `start` pulse in IDLE loads `init_period` and `init_est`. The next cycle raises `req_valid`, with `req_period` = `init_period` and `req_est` = `init_est`.
- R2: At each period end with ne+ns nonzero, the estimate becomes floor(ne*65536/(ne+ns)), saturated to 65535. Here ne = `cnt_err` and ns = `cnt_ok`. The value appears on `est_o` and on the next `req_est`.
- R3: At a period end with ne+ns = 0, the estimate is left unchanged and the period is resized as for a non-rising estimate.
- R4: With `mode_adapt` = 0, the period never changes after start.
- R5: With `mode_adapt` = 1 and a new estimate strictly above the previous one, the next period is P - floor(P*9830/65536). The comparison is exact on the counts, and the first comparison is against `init_est`/65536.
- R6: With `mode_adapt` = 1 and a new estimate equal to or below the previous one, the next period is P + floor(P*9830/65536).
- R7: An adapted period is clamped into [`min_period`, `max_period`].
- R8: The spacing S is P / max(C,1), floored and raised to at least 1, where C is `rsp_count`. On RUN cycle k (k = 0..P-1), `ckpt_strobe` is high for that one cycle exactly when k mod S = S-1.
- R9: The request stays asserted and stable until `rsp_valid`. RUN then lasts exactly P cycles, followed by one cycle of `period_end`, then a new request.
- R10: After reset, `req_valid`, `ckpt_strobe` and `period_end` are low, and `period_o` and `est_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin operation (sampled in IDLE) |
| mode_adapt | input | 1 | 1 = adaptive period, 0 = fixed period |
| init_period | input | PW | Starting period length in cycles |
| min_period | input | PW | Lower clamp for adapted period |
| max_period | input | PW | Upper clamp for adapted period |
| init_est | input | 16 | Starting estimate, Q0.16 |
| cnt_err | input | CW | Faulty segments in the period, sampled in EVAL |
| cnt_ok | input | CW | Clean segments in the period, sampled in EVAL |
| rsp_valid | input | 1 | Lookup response valid |
| rsp_count | input | NW | Checkpoint count for the coming period |
| req_valid | output | 1 | Lookup request pending |
| req_est | output | 16 | Estimate sent with the request |
| req_period | output | PW | Period sent with the request |
| period_o | output | PW | Current period length |
| est_o | output | 16 | Current estimate, Q0.16 |
| ckpt_strobe | output | 1 | One-cycle checkpoint strobe |
| period_end | output | 1 | High during the EVAL cycle |

## Verification
The hardest conditions to reach from the ports are the clamp edges and the empty period. Both depend on the period drifting over several evaluations, not on a single input. The bench therefore plays long chains of per-period counts. These chains walk the period into `max_period` and, from a small start, below `min_period`. They include two empty periods in a row, a saturated estimate with zero clean segments, and an exact tie between estimates. A lookup model answers each request with chosen counts (0, more than the period, and exact divisors) to reach every spacing corner.

// File: rtl/ckp_pkg.sv
package ckp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RUN,
        ST_EVAL
    } ckp_state_e;

    localparam int unsigned EST_W    = 16;
    localparam logic [15:0] ALPHA_Q16 = 16'd9830;
endpackage

// File: rtl/ckp_est_unit.sv
module ckp_est_unit #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_init,
    input  logic [15:0]   init_est,
    input  logic          eval,
    input  logic [CW-1:0] cnt_err,
    input  logic [CW-1:0] cnt_ok,
    output logic [15:0]   est,
    output logic          rising
);
    localparam int DW = (CW + 1 > 17) ? CW + 1 : 17;
    localparam int QW = CW + 16;

    logic [DW-1:0]   prev_num, prev_den, tot;
    logic [2*DW-1:0] lhs, rhs;
    logic [QW-1:0]   num_sh, quo;
    logic [15:0]     est_new;

    always_comb begin
        tot     = DW'(cnt_err) + DW'(cnt_ok);
        lhs     = (2*DW)'(cnt_err) * (2*DW)'(prev_den);
        rhs     = (2*DW)'(prev_num) * (2*DW)'(tot);
        rising  = (tot != '0) && (lhs > rhs);
        num_sh  = {cnt_err, 16'h0000};
        quo     = (tot == '0) ? '0 : num_sh / QW'(tot);
        est_new = (quo > QW'(16'hFFFF)) ? 16'hFFFF : quo[15:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            est      <= '0;
            prev_num <= '0;
            prev_den <= DW'(1);
        end else if (load_init) begin
            est      <= init_est;
            prev_num <= DW'(init_est);
            prev_den <= DW'(17'h10000);
        end else if (eval && tot != '0) begin
            est      <= est_new;
            prev_num <= DW'(cnt_err);
            prev_den <= tot;
        end
    end

    AST_EMPTY_KEEPS_EST: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !load_init && cnt_err == '0 && cnt_ok == '0) |=> $stable(est)); // R3
    AST_SAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !load_init && cnt_err != '0 && cnt_ok == '0) |=> (est == 16'hFFFF)); // R2
endmodule

// File: rtl/ckp_period_upd.sv
module ckp_period_upd
    import ckp_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic [PW-1:0] period,
    input  logic          rising,
    input  logic [PW-1:0] min_p,
    input  logic [PW-1:0] max_p,
    output logic [PW-1:0] next_p
);
    logic [PW+15:0] prod;
    logic [PW-1:0]  delta;
    logic [PW:0]    cand;

    always_comb begin
        prod  = (PW+16)'(period) * (PW+16)'(ALPHA_Q16);
        delta = PW'(prod >> 16);
        cand  = rising ? ({1'b0, period} - {1'b0, delta})
                       : ({1'b0, period} + {1'b0, delta});
        if (cand < {1'b0, min_p})
            next_p = min_p;
        else if (cand > {1'b0, max_p})
            next_p = max_p;
        else
            next_p = cand[PW-1:0];
    end

    always_comb begin
        AST_SHRINK_NOT_ABOVE: assert (!(rising && min_p <= period && period <= max_p) || next_p <= period); // R5
    end
endmodule

// File: rtl/ckp_spacer.sv
module ckp_spacer #(
    parameter int PW = 16,
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [PW-1:0] period,
    input  logic [NW-1:0] count,
    output logic          strobe,
    output logic          last
);
    localparam int MW = (PW > NW) ? PW : NW;

    logic [PW-1:0] spacing, pc, sc, sp_eff;
    logic [MW-1:0] cnt_x, quo;

    always_comb begin
        cnt_x  = (count == '0) ? MW'(1) : MW'(count);
        quo    = MW'(period) / cnt_x;
        sp_eff = (quo == '0) ? PW'(1) : PW'(quo);
        strobe = run && (sc == spacing - PW'(1));
        last   = run && (pc == period - PW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spacing <= PW'(1);
            pc      <= '0;
            sc      <= '0;
        end else if (load) begin
            spacing <= sp_eff;
            pc      <= '0;
            sc      <= '0;
        end else if (run) begin
            pc <= pc + PW'(1);
            sc <= (sc == spacing - PW'(1)) ? '0 : sc + PW'(1);
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && spacing > PW'(1) && !load) |=> !strobe); // R8
endmodule

// File: rtl/ckp_adapt_ctrl.sv
module ckp_adapt_ctrl
    import ckp_pkg::*;
#(
    parameter int PW = 16,
    parameter int CW = 16,
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_adapt,
    input  logic [PW-1:0] init_period,
    input  logic [PW-1:0] min_period,
    input  logic [PW-1:0] max_period,
    input  logic [15:0]   init_est,
    input  logic [CW-1:0] cnt_err,
    input  logic [CW-1:0] cnt_ok,
    input  logic          rsp_valid,
    input  logic [NW-1:0] rsp_count,
    output logic          req_valid,
    output logic [15:0]   req_est,
    output logic [PW-1:0] req_period,
    output logic [PW-1:0] period_o,
    output logic [15:0]   est_o,
    output logic          ckpt_strobe,
    output logic          period_end
);
    ckp_state_e    state_q, state_d;
    logic [PW-1:0] period_q, next_p;
    logic [15:0]   est;
    logic          rising, last, load_init;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_REQ;
            ST_REQ:  if (rsp_valid) state_d = ST_RUN;
            ST_RUN:  if (last)      state_d = ST_EVAL;
            ST_EVAL:                state_d = ST_REQ;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_valid  = (state_q == ST_REQ);
        period_end = (state_q == ST_EVAL);
        load_init  = (state_q == ST_IDLE) && start;
        req_est    = est;
        req_period = period_q;
        period_o   = period_q;
        est_o      = est;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            period_q <= '0;
        else if (load_init)
            period_q <= init_period;
        else if (state_q == ST_EVAL && mode_adapt)
            period_q <= next_p;
    end

    ckp_est_unit #(.CW(CW)) u_est (
        .clk(clk), .rst_n(rst_n), .load_init(load_init), .init_est(init_est),
        .eval(state_q == ST_EVAL), .cnt_err(cnt_err), .cnt_ok(cnt_ok),
        .est(est), .rising(rising)
    );

    ckp_period_upd #(.PW(PW)) u_upd (
        .period(period_q), .rising(rising), .min_p(min_period),
        .max_p(max_period), .next_p(next_p)
    );

    ckp_spacer #(.PW(PW), .NW(NW)) u_sp (
        .clk(clk), .rst_n(rst_n), .load(state_q == ST_REQ && rsp_valid),
        .run(state_q == ST_RUN), .period(period_q), .count(rsp_count),
        .strobe(ckpt_strobe), .last(last)
    );

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_period) && $stable(req_est))); // R9
    AST_END_THEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (!period_end && req_valid)); // R9
    AST_FIXED_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !mode_adapt) |=> $stable(period_o)); // R4
    AST_CLAMP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && mode_adapt && min_period <= max_period)
        |=> (period_o >= $past(min_period) && period_o <= $past(max_period))); // R7
    AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_strobe |-> (!req_valid && !period_end)); // R8
endmodule

// File: tb/ckp_adapt_ctrl_bench.sv
module ckp_adapt_ctrl_bench;
    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_adapt = 1'b0;
    logic [15:0] init_period = '0, min_period = '0, max_period = '0, init_est = '0;
    logic [15:0] cnt_err = '0, cnt_ok = '0, rsp_count = '0;
    logic        rsp_valid = 1'b0;
    logic        req_valid, ckpt_strobe, period_end;
    logic [15:0] req_est, req_period, period_o, est_o;

    always #10 clk = ~clk;

    ckp_adapt_ctrl u_ckp_adapt_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_adapt(mode_adapt),
        .init_period(init_period), .min_period(min_period), .max_period(max_period),
        .init_est(init_est), .cnt_err(cnt_err), .cnt_ok(cnt_ok),
        .rsp_valid(rsp_valid), .rsp_count(rsp_count), .req_valid(req_valid),
        .req_est(req_est), .req_period(req_period), .period_o(period_o),
        .est_o(est_o), .ckpt_strobe(ckpt_strobe), .period_end(period_end)
    );

    typedef struct { longint per; longint est; } exp_t;
    exp_t q[$];
    int   tests = 0, fails = 0;
    int   E[8], O[8], C[8];
    int   n_per = 0, idx = 0, ends = 0, k = 0, cur_p = 0, cur_s = 1, strobes = 0;
    bit   active = 0, running = 0, req_seen = 0, pat_bad = 0, done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected requests, answers the lookup, checks strobes
    always @(negedge clk) begin
        if (rsp_valid) rsp_valid = 1'b0;
        if (active && running) begin
            if (k < cur_p) begin
                if (ckpt_strobe !== ((k % cur_s) == cur_s - 1)) pat_bad = 1;
                if (ckpt_strobe) strobes++;
            end else if (ckpt_strobe) pat_bad = 1;
            if (period_end) begin
                chk(!pat_bad && strobes == cur_p / cur_s, "R8 strobe pattern/count",
                    strobes, cur_p / cur_s);
                chk(k == cur_p, "R9 run length", k, cur_p);
                running = 0; req_seen = 0; ends++;
            end
            k++;
        end else if (active && req_valid && !req_seen && idx < n_per) begin
            exp_t e;
            e = q.pop_front();
            req_seen = 1;
            chk(req_period == e.per, "R5/R6/R7/R4 req_period", req_period, e.per);
            chk(req_est == e.est, "R2/R3 req_est", req_est, e.est);
            cur_p = int'(e.per);
            cur_s = cur_p / ((C[idx] == 0) ? 1 : C[idx]);
            if (cur_s == 0) cur_s = 1;
            cnt_err = 16'(E[idx]); cnt_ok = 16'(O[idx]); rsp_count = 16'(C[idx]);
            rsp_valid = 1'b1;
            idx++; k = 0; strobes = 0; pat_bad = 0; running = 1;
        end
    end

    // Driver: resets, configures, pushes expected items, starts
    task automatic run_scn(input bit md, input int ip, input int ie, input int mn,
                           input int mx, input int n);
        longint p, est, pn, pd, tot, dl;
        bit up;
        rst_n = 1'b0; start = 1'b0; active = 0;
        mode_adapt = md; init_period = 16'(ip); init_est = 16'(ie);
        min_period = 16'(mn); max_period = 16'(mx);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(period_o == 0 && est_o == 0, "R10 reset values", period_o, 0);
        chk(!req_valid && !ckpt_strobe && !period_end, "R10 reset controls",
            {req_valid, ckpt_strobe, period_end}, 0);
        p = ip; est = ie; pn = ie; pd = 65536;
        for (int i = 0; i < n; i++) begin
            q.push_back('{per: p, est: est});
            tot = E[i] + O[i];
            up = (tot != 0) && (longint'(E[i]) * pd > pn * tot);
            if (tot != 0) begin
                est = (longint'(E[i]) * 65536) / tot;
                if (est > 65535) est = 65535;
                pn = E[i]; pd = tot;
            end
            if (md) begin
                dl = (p * 9830) / 65536;
                p = up ? p - dl : p + dl;
                if (p < mn) p = mn;
                if (p > mx) p = mx;
            end
        end
        n_per = n; idx = 0; ends = 0; running = 0; req_seen = 0; active = 1;
        repeat (2) @(negedge clk);
        chk(!req_valid, "R1 no request before start", req_valid, 0);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(req_valid && req_period == 16'(ip), "R1 start loads period", req_period, ip);
        while (ends < n) @(negedge clk);
        active = 0;
        chk(q.size() == 0, "R9 all periods seen", q.size(), 0);
    endtask

    initial begin
        // rise, tie, drop to 0, two empty periods, max clamp, saturation, tie
        E = '{1, 1, 0, 0, 0, 0, 5, 5};
        O = '{9, 9, 10, 0, 0, 5, 0, 0};
        C = '{4, 5, 0, 100, 3, 2, 7, 1};
        run_scn(1'b1, 40, 2048, 20, 60, 8);   // R5 R6 R3 R7 R8 R2
        E = '{3, 1, 0, 0, 0, 0, 0, 0};
        O = '{1, 1, 0, 0, 0, 0, 0, 0};
        C = '{2, 3, 0, 0, 0, 0, 0, 0};
        run_scn(1'b1, 22, 0, 20, 60, 2);      // R7 min clamp, R6
        E = '{4, 0, 2, 0, 0, 0, 0, 0};
        O = '{4, 6, 0, 0, 0, 0, 0, 0};
        C = '{3, 6, 0, 0, 0, 0, 0, 0};
        run_scn(1'b0, 30, 100, 20, 60, 3);    // R4 fixed period
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", ends, n_per);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule